// File: doc/BRIEF.md
# Bit-Field Extract Execute Unit

This unit executes a pair of custom instructions that pull a narrow bit field, one to eight bits wide, out of a 32-bit source register. It takes the raw 32-bit instruction word and the values of both source operands. It returns the destination register index, the zero-extended field, a write-enable and a flag for encodings that fall in the custom opcode space but are not recognised. The unit is purely combinational and sits in the execute stage of a core. That core already fetches the word and reads the register file.

The starting bit position comes from one of two places. The register form takes it from the full 32-bit value of the second source operand. The immediate form takes it from a 5-bit field in the instruction word, which then does not name a register. A field that runs past bit 31 of the source is filled with zeros there, and so is one that starts at position 32 or beyond.

Top module: `bfx_unit`

## Requirements
- R1: When instruction bits 6:0 differ from 0x0B, wr_en_o and bad_enc_o are 0 and result_o is 0.
- R2: With opcode 0x0B and bits 14:12 equal to 0 (register form), the start position is the full 32-bit value of rs2_val_i, and result bit i equals rs1_val_i bit (start+i).
- R3: With opcode 0x0B and bits 14:12 equal to 4 (immediate form), the start position is instruction bits 24:20 (0 to 31), and rs2_val_i has no effect on any output.
- R4: Instruction bits 28:26 hold the field width minus one. Result bits at or above the width are 0.
- R5: Any source position above 31 reads as 0. A register-form start of 32 or more gives a result of 0.
- R6: rd_idx_o always equals instruction bits 11:7. When it is 0, wr_en_o is 0 even for a valid extract. Otherwise a valid extract sets wr_en_o to 1.
- R7: With opcode 0x0B and any bits 14:12 other than 0 or 4, bad_enc_o is 1, wr_en_o is 0 and result_o is 0.
- R8: Instruction bits 31:29 and bit 25 have no effect on any output.
- R9: With rs1 = 0xDEADBEEF, register-form start 4 and width 6 give 0x2E. Immediate start 16 and width 3 give 0x5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word under execution |
| rs1_val_i | input | 32 | Value of the source register holding the field |
| rs2_val_i | input | 32 | Value of the second source register (start position in register form) |
| rd_idx_o | output | 5 | Destination register index taken from the instruction |
| result_o | output | 32 | Extracted field, zero-extended |
| wr_en_o | output | 1 | Result should be written to the destination register |
| bad_enc_o | output | 1 | Custom opcode with an unrecognised function code |

## Verification
The hardest cases to reach are the start values that wrap past the top of the source. One is a register start near 0xFFFFFFFF, where a narrow adder would roll over to a small index and wrongly pick up low bits. The other is a start of 28 to 31 with a wide field, where only part of the field lies inside the word. Random operands almost never produce either. The stimulus therefore drives directed starts of 31, 32, 33 and 0xFFFFFFF9 to 0xFFFFFFFF at width 8. Random words then sweep every function code, width and reserved-bit pattern against the behavioural model, and the immediate form gets a varying rs2 value to show that rs2 does not leak into the result.

// File: rtl/bfx_pkg.sv
// Package: shared constants and types for the bit-field extract unit.
// Assumes a 32-bit instruction word with the standard R/I field layout.
package bfx_pkg;

    localparam int unsigned INSN_W     = 32;
    localparam int unsigned REG_IDX_W  = 5;
    localparam logic [6:0]  OPC_CUSTOM = 7'h0B;
    localparam logic [2:0]  FN_REG     = 3'd0;
    localparam logic [2:0]  FN_IMM     = 3'd4;

    // Decoded operation class.
    typedef enum logic [1:0] {
        BFX_NONE = 2'd0,
        BFX_REG  = 2'd1,
        BFX_IMM  = 2'd2,
        BFX_BAD  = 2'd3
    } bfx_op_e;

endpackage

// File: rtl/bfx_decode.sv
// Module: bfx_decode
// Splits the instruction word into operation class, destination index,
// immediate start and width-minus-one. Assumes the field width fits the
// 3-bit encoding at bits 28:26; bits 31:29 and 25 are deliberately unused.
module bfx_decode
    import bfx_pkg::*;
#(
    parameter int unsigned WM1_W = 3
) (
    input  logic [INSN_W-1:0]    instr_i,
    output bfx_op_e              op_o,
    output logic [REG_IDX_W-1:0] rd_o,
    output logic [4:0]           imm_start_o,
    output logic [WM1_W-1:0]     wm1_o
);

    logic [6:0] opc;
    logic [2:0] fn;
    logic       unused_bits;

    // Field slicing from fixed instruction positions.
    always_comb begin
        opc         = instr_i[6:0];
        fn          = instr_i[14:12];
        rd_o        = instr_i[11:7];
        imm_start_o = instr_i[24:20];
        wm1_o       = instr_i[26 +: WM1_W];
    end

    assign unused_bits = ^{instr_i[31:29], instr_i[25], instr_i[19:15]};

    // Operation class from opcode and function code.
    always_comb begin
        if (opc != OPC_CUSTOM)  op_o = BFX_NONE;
        else if (fn == FN_REG)  op_o = BFX_REG;
        else if (fn == FN_IMM)  op_o = BFX_IMM;
        else                    op_o = BFX_BAD;
    end

    // Guard: a recognised class implies the custom opcode (R1, R7).
    always_comb begin
        p_class_opcode_r1: assert ((op_o == BFX_NONE) || (instr_i[6:0] == OPC_CUSTOM))
            else $error("op class set without custom opcode");
    end

endmodule

// File: rtl/bfx_extract.sv
// Module: bfx_extract
// Gathers up to MAXW bits of src_i starting at start_i. Each output lane
// has its own position adder one bit wider than start_i so that large
// starts never wrap. Positions at or past XLEN read as zero.
module bfx_extract #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned MAXW  = 8,
    parameter int unsigned WM1_W = $clog2(MAXW)
) (
    input  logic [XLEN-1:0]  src_i,
    input  logic [XLEN-1:0]  start_i,
    input  logic [WM1_W-1:0] wm1_i,
    output logic [XLEN-1:0]  field_o
);

    localparam int unsigned IDXW = $clog2(XLEN);
    localparam int unsigned POSW = XLEN + 1;

    // One lane per possible field bit.
    for (genvar gi = 0; gi < MAXW; gi++) begin : g_lane
        logic [POSW-1:0] pos;
        logic            in_word;
        logic            enabled;
        assign pos     = {1'b0, start_i} + POSW'(gi);
        assign in_word = pos < POSW'(XLEN);
        assign enabled = WM1_W'(gi) <= wm1_i;
        assign field_o[gi] = enabled && in_word && src_i[pos[IDXW-1:0]];
    end

    // Bits beyond the widest field are always clear.
    assign field_o[XLEN-1:MAXW] = '0;

    // Guard: a start past the word yields an empty field (R5).
    always_comb begin
        p_past_end_r5: assert ((start_i < XLEN) || (field_o == '0))
            else $error("field nonzero with start past word");
    end

endmodule

// File: rtl/bfx_unit.sv
// Module: bfx_unit (top)
// Combinational execute unit for the register-start and immediate-start
// bit-field extract instructions. Assumes operands are already read;
// the result is zero and no write occurs for anything not recognised.
module bfx_unit
    import bfx_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned MAXW = 8
) (
    input  logic [INSN_W-1:0]    instr_i,
    input  logic [XLEN-1:0]      rs1_val_i,
    input  logic [XLEN-1:0]      rs2_val_i,
    output logic [REG_IDX_W-1:0] rd_idx_o,
    output logic [XLEN-1:0]      result_o,
    output logic                 wr_en_o,
    output logic                 bad_enc_o
);

    localparam int unsigned WM1_W = $clog2(MAXW);

    bfx_op_e          op;
    logic [4:0]       imm_start;
    logic [WM1_W-1:0] wm1;
    logic [XLEN-1:0]  start;
    logic [XLEN-1:0]  field;
    logic             valid;

    bfx_decode #(.WM1_W(WM1_W)) u_decode (
        .instr_i     (instr_i),
        .op_o        (op),
        .rd_o        (rd_idx_o),
        .imm_start_o (imm_start),
        .wm1_o       (wm1)
    );

    // Start-position source select.
    always_comb begin
        start = (op == BFX_IMM) ? XLEN'(imm_start) : rs2_val_i;
    end

    bfx_extract #(.XLEN(XLEN), .MAXW(MAXW), .WM1_W(WM1_W)) u_extract (
        .src_i   (rs1_val_i),
        .start_i (start),
        .wm1_i   (wm1),
        .field_o (field)
    );

    // Output qualification.
    always_comb begin
        valid     = (op == BFX_REG) || (op == BFX_IMM);
        result_o  = valid ? field : '0;
        wr_en_o   = valid && (rd_idx_o != '0);
        bad_enc_o = (op == BFX_BAD);
    end

    // Guards on the port-level contract.
    always_comb begin
        p_rd_zero_r6: assert ((rd_idx_o != '0) || !wr_en_o)
            else $error("write enabled to register zero");
        p_no_write_bad_r7: assert (!(bad_enc_o && wr_en_o))
            else $error("write enabled on bad encoding");
        p_width_mask_r4: assert ((result_o >> (32'(wm1) + 32'd1)) == '0)
            else $error("result bits above width set");
        p_excl_flags_r7: assert ($onehot0({bad_enc_o, valid}))
            else $error("bad and valid together");
    end

endmodule

// File: tb/bfx_unit_tb.sv
module bfx_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [4:0]  rd_idx;
    logic [31:0] result;
    logic        wr_en;
    logic        bad_enc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    bfx_unit u_dut (
        .instr_i   (instr),
        .rs1_val_i (a),
        .rs2_val_i (b),
        .rd_idx_o  (rd_idx),
        .result_o  (result),
        .wr_en_o   (wr_en),
        .bad_enc_o (bad_enc)
    );

    function automatic logic [31:0] mk(input logic [2:0] hi, input logic [2:0] wm1,
                                       input logic b25, input logic [4:0] f2,
                                       input logic [4:0] f1, input logic [2:0] fn,
                                       input logic [4:0] rd, input logic [6:0] opc);
        return {hi, wm1, b25, f2, f1, fn, rd, opc};
    endfunction

    // Behavioural model: loop over field bits using integer arithmetic.
    task automatic model(input logic [31:0] w, input logic [31:0] s1, input logic [31:0] s2,
                         output logic [4:0] e_rd, output logic [31:0] e_res,
                         output logic e_we, output logic e_bad);
        longint st;
        int     width;
        bit     cust, ok;
        cust  = (w[6:0] == 7'h0B);
        ok    = cust && (w[14:12] == 3'd0 || w[14:12] == 3'd4);
        e_rd  = w[11:7];
        e_bad = cust && !ok;
        e_we  = ok && (w[11:7] != 0);
        e_res = '0;
        st    = (w[14:12] == 3'd4) ? longint'(w[24:20]) : longint'(s2);
        width = int'(w[28:26]) + 1;
        if (ok)
            for (int i = 0; i < width; i++)
                if (st + i < 32) e_res[i] = s1[int'(st + i)];
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply a vector after a rising edge, check all outputs at the falling edge.
    task automatic run(input string tag, input logic [31:0] w, input logic [31:0] s1,
                       input logic [31:0] s2);
        logic [4:0] e_rd; logic [31:0] e_res; logic e_we, e_bad;
        @(posedge clk); #1;
        instr = w; a = s1; b = s2;
        @(negedge clk);
        model(w, s1, s2, e_rd, e_res, e_we, e_bad);
        chk({tag, " rd"},  32'(rd_idx),  32'(e_rd));
        chk({tag, " res"}, result,       e_res);
        chk({tag, " we"},  32'(wr_en),   32'(e_we));
        chk({tag, " bad"}, 32'(bad_enc), 32'(e_bad));
    endtask

    initial begin
        logic [31:0] keep;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Quiescent state with an all-zero word (R1).
        @(negedge clk);
        chk("R1 idle res", result, 32'h0);
        chk("R1 idle we",  32'(wr_en), 32'h0);
        chk("R1 idle bad", 32'(bad_enc), 32'h0);

        // R9 known examples.
        run("R9 reg ex", mk(3'd0, 3'd5, 1'b0, 5'd6, 5'd5, 3'd0, 5'd8, 7'h0B), 32'hDEADBEEF, 32'd4);
        chk("R9 reg 0x2E", result, 32'h2E);
        run("R9 imm ex", mk(3'd0, 3'd2, 1'b0, 5'd16, 5'd5, 3'd4, 5'd9, 7'h0B), 32'hDEADBEEF, 32'd99);
        chk("R9 imm 0x5", result, 32'h5);

        // R1 other opcodes.
        run("R1 opc33", mk(3'd0, 3'd7, 1'b0, 5'd0, 5'd1, 3'd0, 5'd3, 7'h33), 32'hFFFFFFFF, 32'd0);
        run("R1 opc0A", mk(3'd0, 3'd7, 1'b0, 5'd0, 5'd1, 3'd4, 5'd3, 7'h0A), 32'hFFFFFFFF, 32'd0);

        // R2 register start sweep, width 8.
        for (int s = 0; s < 32; s++)
            run("R2 sweep", mk(3'd0, 3'd7, 1'b0, 5'd2, 5'd1, 3'd0, 5'd4, 7'h0B), 32'hA5C3_96F0, 32'(s));

        // R5 past-end starts, including wrap-prone values.
        run("R5 s31", mk(3'd0, 3'd7, 1'b0, 5'd2, 5'd1, 3'd0, 5'd4, 7'h0B), 32'hFFFFFFFF, 32'd31);
        chk("R5 s31 one bit", result, 32'h1);
        run("R5 s32", mk(3'd0, 3'd7, 1'b0, 5'd2, 5'd1, 3'd0, 5'd4, 7'h0B), 32'hFFFFFFFF, 32'd32);
        chk("R5 s32 zero", result, 32'h0);
        run("R5 s33", mk(3'd0, 3'd7, 1'b0, 5'd2, 5'd1, 3'd0, 5'd4, 7'h0B), 32'hFFFFFFFF, 32'd33);
        for (int k = 0; k < 7; k++)
            run("R5 wrap", mk(3'd0, 3'd7, 1'b0, 5'd2, 5'd1, 3'd0, 5'd4, 7'h0B), 32'hFFFFFFFF,
                32'hFFFFFFF9 + 32'(k));
        run("R5 imm28", mk(3'd0, 3'd7, 1'b0, 5'd28, 5'd1, 3'd4, 5'd4, 7'h0B), 32'hFFFFFFFF, 32'd0);
        chk("R5 imm28 four", result, 32'hF);

        // R4 every width.
        for (int w = 0; w < 8; w++)
            run("R4 width", mk(3'd0, 3'(w), 1'b0, 5'd3, 5'd1, 3'd4, 5'd7, 7'h0B), 32'hFFFFFFFF, 32'd0);

        // R3 rs2 has no effect in immediate form.
        run("R3 base", mk(3'd0, 3'd7, 1'b0, 5'd9, 5'd1, 3'd4, 5'd7, 7'h0B), 32'h1234_5678, 32'd0);
        keep = result;
        run("R3 rs2 alt", mk(3'd0, 3'd7, 1'b0, 5'd9, 5'd1, 3'd4, 5'd7, 7'h0B), 32'h1234_5678, 32'hFFFF_FFFF);
        chk("R3 rs2 ignored", result, keep);

        // R6 destination zero.
        run("R6 rd0", mk(3'd0, 3'd7, 1'b0, 5'd0, 5'd1, 3'd0, 5'd0, 7'h0B), 32'hFFFFFFFF, 32'd0);
        chk("R6 rd0 no write", 32'(wr_en), 32'h0);
        run("R6 rd31", mk(3'd0, 3'd7, 1'b0, 5'd0, 5'd1, 3'd0, 5'd31, 7'h0B), 32'hFFFFFFFF, 32'd0);
        chk("R6 rd31 write", 32'(wr_en), 32'h1);

        // R7 unused function codes.
        for (int f = 0; f < 8; f++)
            run("R7 fn", mk(3'd0, 3'd7, 1'b0, 5'd1, 5'd1, 3'(f), 5'd5, 7'h0B), 32'hFFFFFFFF, 32'd1);

        // R8 reserved bits.
        run("R8 base", mk(3'd0, 3'd4, 1'b0, 5'd11, 5'd1, 3'd4, 5'd6, 7'h0B), 32'hCAFE_F00D, 32'd2);
        keep = result;
        run("R8 set", mk(3'd7, 3'd4, 1'b1, 5'd11, 5'd1, 3'd4, 5'd6, 7'h0B), 32'hCAFE_F00D, 32'd2);
        chk("R8 ignored", result, keep);

        // Random words over all fields (R2, R3, R4, R7, R8).
        for (int r = 0; r < 3000; r++) begin
            logic [31:0] w;
            w = $urandom;
            if (r % 4 != 3) w[6:0] = 7'h0B;
            if (r % 3 == 0) w[14:12] = 3'd0;
            if (r % 3 == 1) w[14:12] = 3'd4;
            run("R2 R3 R4 R7 R8 random", w, $urandom, (r % 5 == 0) ? $urandom : ($urandom % 40));
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule